// File: doc/BRIEF.md
# SD Card Data Buffer with Transfer Debug Word

This block buffers data words between the host register bus and the card-side data path of an SD host controller. A 16-entry, 32-bit first-in-first-out store sits between a single host data register and a valid/ready word port facing the card. In the write direction the host fills the store and the card side drains it. In the read direction the card side fills it and the host reads it.

A small transfer sequencer counts words into blocks and blocks down to zero, then returns to its idle data state and raises a block-done flag. A single debug word reports, together, the 4-bit sequencer state, the current fill level and both programmable request thresholds. Writing a recovery bit in that word pulls a stalled read, read-wait or write-start state back to idle data mode. The status word carries a data-request flag, derived from the thresholds, which drives the software's burst loop.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset the debug word reads 0x00010800: state 0 (identification), fill 0, both thresholds 4. The status word reads 0, the block count reads 0 and the control word reads 0.
- R2: Words leave in the order they entered. Host data writes emerge on `tx_data`, and `rx_data` words return on host data reads. An accepted card-side word always leaves the fill level non-zero.
- R3: Register map by word address: 0 control, 1 status, 2 debug, 3 block size in bytes, 4 block count, 5 data. Debug bits 3:0 hold the state, 8:4 the fill level, 13:9 the write threshold and 18:14 the read threshold. Both thresholds can be written and read back.
- R4: A host data write in the write direction while the store holds 16 words is dropped and sets status bit 3. The fill level stays at 16 and the dropped word never reaches `tx_data`.
- R5: A host data read in the read direction while the store is empty returns the last word read, sets status bit 3 and leaves the fill level at 0.
- R6: Writing 1 to status bit 3 or bit 9 clears that bit. Writing 0 to a bit leaves it unchanged.
- R7: Status bit 0 (data request) is 1 during a read transfer (state 2 or 4) when the fill level is at or above the read threshold.
- R8: Status bit 0 is 1 during a write transfer (state 10 or 3) when the fill level is at or below 16 minus the write threshold. It is 0 when no transfer is active (state 0 or 1).
- R9: A read transfer sits in state 2 (read data) with `rx_ready` high while there is room. It moves to state 4 (read wait) with `rx_ready` low when the store is full, and returns to state 2 once a word is read.
- R10: A write transfer starts in state 10 (write start 1) and moves to state 3 (write data) once the store is non-empty. It returns to state 10 when the store empties. A presented `tx_data` word stays stable until it is taken.
- R11: Each block of (byte size / 4) card-side words decrements the block count. When the count reaches zero the state returns to 1 (data mode) and status bit 9 is set.
- R12: A debug write with bit 19 set moves state 2, 4 or 10 to state 1. In state 3 it has no effect.
- R13: A control write with bit 0 (go) starts a transfer only from state 0 or 1 with a non-zero block count. Bit 1 selects the direction (1 = read, card to host). While the last direction is read, host data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_en | input | 1 | Host register access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| rx_valid | input | 1 | Card-side word available |
| rx_data | input | 32 | Card-side word into the store |
| rx_ready | output | 1 | Store accepts a card-side word |
| tx_valid | output | 1 | Word available for the card side |
| tx_data | output | 32 | Head word toward the card side |
| tx_ready | input | 1 | Card side takes the word |

## Verification
The bench drives the store to exactly 16 entries and pushes one more word. A design that wrapped its write pointer would overwrite the oldest word, which the scoreboard catches, or it would leave a stray word, which shows up as a non-zero final fill level. The bench steps the fill level across each threshold edge (3 to 4 for reads, 12 to 13 for writes), so an off-by-one in either comparison flips the request flag at the wrong count. It also stalls a read transfer at full to catch a design that never leaves read-wait or keeps accepting words. It reads an empty store to catch a stale or zero return value. It then aims the recovery bit at both a recoverable state and write data, where a design that ignores the state qualifier would abandon a live transfer.

// File: rtl/sdf_pkg.sv
// Shared types and register layout for the SD data buffer.
// Assumes a 32-bit host bus with word addresses.
package sdf_pkg;

    typedef enum logic [3:0] {
        ST_IDENT     = 4'h0,
        ST_DATA      = 4'h1,
        ST_RD_DATA   = 4'h2,
        ST_WR_DATA   = 4'h3,
        ST_RD_WAIT   = 4'h4,
        ST_RD_CRC    = 4'h5,
        ST_WR_CRC    = 4'h6,
        ST_WR_WAIT1  = 4'h7,
        ST_PWR_DOWN  = 4'h8,
        ST_PWR_UP    = 4'h9,
        ST_WR_START1 = 4'hA,
        ST_WR_START2 = 4'hB,
        ST_GEN_PULSE = 4'hC,
        ST_WR_WAIT2  = 4'hD,
        ST_START_PD  = 4'hF
    } dstate_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_DBG   = 3'd2;
    localparam logic [2:0] A_BYTES = 3'd3;
    localparam logic [2:0] A_BLKS  = 3'd4;
    localparam logic [2:0] A_DATA  = 3'd5;

    localparam int unsigned CTRL_GO_BIT  = 0;
    localparam int unsigned CTRL_DIR_BIT = 1;
    localparam int unsigned STAT_REQ_BIT = 0;
    localparam int unsigned STAT_ERR_BIT = 3;
    localparam int unsigned STAT_BLK_BIT = 9;
    localparam int unsigned DBG_ST_W     = 4;

endpackage

// File: rtl/sdf_fifo.sv
// Word store: DEPTH entries of DW bits, with one push port and one pop port.
// Assumes the caller never requests a push into a full store or a pop from an
// empty one; such requests are ignored here.
module sdf_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 32,
    localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              pop_i,
    output logic [DW-1:0]     head_o,
    output logic [FILL_W-1:0] fill_o,
    output logic              full_o,
    output logic              empty_o
);

    logic [DW-1:0]     mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [FILL_W-1:0] fill_q;
    logic              do_push, do_pop;

    // Flags and the effective push and pop requests.
    always_comb begin
        full_o  = (fill_q == FILL_W'(DEPTH));
        empty_o = (fill_q == '0);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        fill_o  = fill_q;
        head_o  = mem[rd_ptr];
    end

    // Storage write; the array is not reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    // Pointer and fill-level bookkeeping, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      fill_q <= fill_q + 1'b1;
            else if (do_pop && !do_push) fill_q <= fill_q - 1'b1;
        end
    end

endmodule

// File: rtl/sdf_xfer_fsm.sv
// Transfer sequencer: tracks the data-path state, counts card-side words into
// blocks and counts blocks down to zero. Assumes words_i is at least 1 and is
// held constant during a transfer.
module sdf_xfer_fsm
    import sdf_pkg::*;
#(
    parameter int unsigned WC_W   = 14,
    parameter int unsigned BCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              go_dir_i,
    input  logic              blk_we_i,
    input  logic [BCNT_W-1:0] blk_wdata_i,
    input  logic [WC_W-1:0]   words_i,
    input  logic              force_i,
    input  logic              rx_fire_i,
    input  logic              tx_fire_i,
    input  logic              full_i,
    input  logic              empty_i,
    output dstate_e           state_o,
    output logic              dir_o,
    output logic [BCNT_W-1:0] blk_left_o,
    output logic              last_o
);

    dstate_e           state_q;
    logic              dir_q;
    logic [BCNT_W-1:0] blk_q;
    logic [WC_W-1:0]   wcnt_q;
    logic              idle, beat, last_beat, start, force_ok;

    // Event decode for the current cycle.
    always_comb begin
        idle      = (state_q == ST_IDENT) || (state_q == ST_DATA);
        beat      = dir_q ? rx_fire_i : tx_fire_i;
        last_beat = beat && (wcnt_q == words_i - 1'b1);
        last_o    = last_beat && (blk_q == BCNT_W'(1));
        start     = go_i && idle && (blk_q != '0);
        force_ok  = force_i && ((state_q == ST_RD_DATA) || (state_q == ST_RD_WAIT) ||
                                (state_q == ST_WR_START1));
        state_o    = state_q;
        dir_o      = dir_q;
        blk_left_o = blk_q;
    end

    // Data-path state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDENT;
        end else if (start) begin
            state_q <= go_dir_i ? ST_RD_DATA : ST_WR_START1;
        end else if (last_o || force_ok) begin
            state_q <= ST_DATA;
        end else begin
            case (state_q)
                ST_RD_DATA:   if (full_i)   state_q <= ST_RD_WAIT;
                ST_RD_WAIT:   if (!full_i)  state_q <= ST_RD_DATA;
                ST_WR_START1: if (!empty_i) state_q <= ST_WR_DATA;
                ST_WR_DATA:   if (empty_i)  state_q <= ST_WR_START1;
                default:      state_q <= state_q;
            endcase
        end
    end

    // Direction latch, word counter and block counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            wcnt_q <= '0;
            blk_q  <= '0;
        end else begin
            if (start) begin
                dir_q  <= go_dir_i;
                wcnt_q <= '0;
            end else if (beat) begin
                wcnt_q <= last_beat ? '0 : wcnt_q + 1'b1;
            end
            if (blk_we_i && idle)  blk_q <= blk_wdata_i;
            else if (last_beat)    blk_q <= blk_q - 1'b1;
        end
    end

endmodule

// File: rtl/sd_data_fifo.sv
// SD data buffer top: host register decode, debug and status words, the word
// store and the transfer sequencer. Assumes DW >= 20 so the debug fields fit,
// and one host access per cycle.
module sd_data_fifo
    import sdf_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned DW      = 32,
    parameter int unsigned BSIZE_W = 16,
    parameter int unsigned BCNT_W  = 9,
    parameter int unsigned RST_THR = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_en,
    input  logic          host_we,
    input  logic [2:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    input  logic          tx_ready
);

    localparam int unsigned FILL_W    = $clog2(DEPTH + 1);
    localparam int unsigned WC_W      = BSIZE_W - 2;
    localparam int unsigned FILL_LSB  = DBG_ST_W;
    localparam int unsigned WTHR_LSB  = FILL_LSB + FILL_W;
    localparam int unsigned RTHR_LSB  = WTHR_LSB + FILL_W;
    localparam int unsigned FORCE_BIT = RTHR_LSB + FILL_W;

    logic [FILL_W-1:0]  fill, thr_w_q, thr_r_q;
    logic [BSIZE_W-1:0] bytes_q;
    logic [DW-1:0]      head, last_q, push_data;
    logic [WC_W-1:0]    words;
    logic [BCNT_W-1:0]  blk_left;
    logic               full, empty, dir, xfer_last;
    logic               host_wr, host_rd, data_wr, data_rd;
    logic               push, pop, rx_fire, tx_fire, go, force_req;
    logic               ferr_q, bdone_q, ferr_set, dreq, rd_act, wr_act;
    dstate_e            state;

    // Host access decode.
    always_comb begin
        host_wr   = host_en && host_we;
        host_rd   = host_en && !host_we;
        data_wr   = host_wr && (host_addr == A_DATA);
        data_rd   = host_rd && (host_addr == A_DATA);
        go        = host_wr && (host_addr == A_CTRL) && host_wdata[CTRL_GO_BIT];
        force_req = host_wr && (host_addr == A_DBG) && host_wdata[FORCE_BIT];
        words     = (bytes_q[BSIZE_W-1:2] == '0) ? WC_W'(1) : bytes_q[BSIZE_W-1:2];
    end

    // Data path steering: direction picks who fills and who drains the store.
    always_comb begin
        rx_ready  = (state == ST_RD_DATA) && !full;
        tx_valid  = (state == ST_WR_DATA) && !empty;
        tx_data   = head;
        rx_fire   = rx_valid && rx_ready;
        tx_fire   = tx_valid && tx_ready;
        push      = dir ? rx_fire : data_wr;
        push_data = dir ? rx_data : host_wdata;
        pop       = dir ? data_rd : tx_fire;
        ferr_set  = (data_wr && !dir && full) || (data_rd && dir && empty);
    end

    // Data-request flag from the fill level and the active threshold.
    always_comb begin
        rd_act = (state == ST_RD_DATA) || (state == ST_RD_WAIT);
        wr_act = (state == ST_WR_START1) || (state == ST_WR_DATA);
        dreq   = (rd_act && (fill >= thr_r_q)) ||
                 (wr_act && (({1'b0, fill} + {1'b0, thr_w_q}) <= (FILL_W + 1)'(DEPTH)));
    end

    // Programmable registers, sticky status flags and the last-read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_w_q <= FILL_W'(RST_THR);
            thr_r_q <= FILL_W'(RST_THR);
            bytes_q <= '0;
            ferr_q  <= 1'b0;
            bdone_q <= 1'b0;
            last_q  <= '0;
        end else begin
            if (host_wr && (host_addr == A_DBG)) begin
                thr_w_q <= host_wdata[WTHR_LSB +: FILL_W];
                thr_r_q <= host_wdata[RTHR_LSB +: FILL_W];
            end
            if (host_wr && (host_addr == A_BYTES)) bytes_q <= host_wdata[BSIZE_W-1:0];
            if (ferr_set) ferr_q <= 1'b1;
            else if (host_wr && (host_addr == A_STAT) && host_wdata[STAT_ERR_BIT]) ferr_q <= 1'b0;
            if (xfer_last) bdone_q <= 1'b1;
            else if (host_wr && (host_addr == A_STAT) && host_wdata[STAT_BLK_BIT]) bdone_q <= 1'b0;
            if (data_rd && dir && !empty) last_q <= head;
        end
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_CTRL:  host_rdata[CTRL_DIR_BIT] = dir;
            A_STAT: begin
                host_rdata[STAT_REQ_BIT] = dreq;
                host_rdata[STAT_ERR_BIT] = ferr_q;
                host_rdata[STAT_BLK_BIT] = bdone_q;
            end
            A_DBG: begin
                host_rdata[DBG_ST_W-1:0]         = state;
                host_rdata[FILL_LSB +: FILL_W]   = fill;
                host_rdata[WTHR_LSB +: FILL_W]   = thr_w_q;
                host_rdata[RTHR_LSB +: FILL_W]   = thr_r_q;
            end
            A_BYTES: host_rdata[BSIZE_W-1:0] = bytes_q;
            A_BLKS:  host_rdata[BCNT_W-1:0]  = blk_left;
            A_DATA:  host_rdata = (dir && !empty) ? head : last_q;
            default: host_rdata = '0;
        endcase
    end

    sdf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wdata_i (push_data),
        .pop_i   (pop),
        .head_o  (head),
        .fill_o  (fill),
        .full_o  (full),
        .empty_o (empty)
    );

    sdf_xfer_fsm #(.WC_W(WC_W), .BCNT_W(BCNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .go_dir_i    (host_wdata[CTRL_DIR_BIT]),
        .blk_we_i    (host_wr && (host_addr == A_BLKS)),
        .blk_wdata_i (host_wdata[BCNT_W-1:0]),
        .words_i     (words),
        .force_i     (force_req),
        .rx_fire_i   (rx_fire),
        .tx_fire_i   (tx_fire),
        .full_i      (full),
        .empty_i     (empty),
        .state_o     (state),
        .dir_o       (dir),
        .blk_left_o  (blk_left),
        .last_o      (xfer_last)
    );

endmodule

// File: rtl/sd_data_fifo_chk.sv
// Protocol checker for the SD data buffer, attached to the top by bind.
// Assumes the default debug layout derived from DEPTH.
module sd_data_fifo_chk
    import sdf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 32,
    localparam int unsigned FILL_W    = $clog2(DEPTH + 1),
    localparam int unsigned FORCE_BIT = DBG_ST_W + 3 * FILL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_en,
    input logic              host_we,
    input logic [2:0]        host_addr,
    input logic [DW-1:0]     host_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DW-1:0]     tx_data,
    input logic [FILL_W-1:0] fill,
    input logic              full,
    input logic              dir,
    input dstate_e           state,
    input logic              ferr_q,
    input logic              bdone_q,
    input logic              xfer_last
);

    // R2
    rx_accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (fill != '0));

    // R4
    full_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && host_we && (host_addr == A_DATA) && !dir && full) |=> ferr_q);

    // R9
    full_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid) |-> !rx_ready);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R11
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |=> ((state == ST_DATA) && bdone_q));

    // R12
    force_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && host_we && (host_addr == A_DBG) && host_wdata[FORCE_BIT] && !xfer_last &&
         ((state == ST_RD_DATA) || (state == ST_RD_WAIT) || (state == ST_WR_START1)))
        |=> (state == ST_DATA));

endmodule

bind sd_data_fifo sd_data_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_en    (host_en),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .fill       (fill),
    .full       (full),
    .dir        (dir),
    .state      (state),
    .ferr_q     (ferr_q),
    .bdone_q    (bdone_q),
    .xfer_last  (xfer_last)
);

// File: tb/sd_data_fifo_tb.sv
// Scoreboard bench: host-side drivers queue expected words, a monitor on the
// card side and the host read task pop and compare them.
module sd_data_fifo_tb;
    import sdf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_en = 1'b0, host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        rx_valid = 1'b0, rx_ready;
    logic [31:0] rx_data = '0;
    logic        tx_valid, tx_ready = 1'b0;
    logic [31:0] tx_data;

    int          n_chk = 0, n_fail = 0;
    logic [31:0] exp_tx[$];
    logic [31:0] exp_rx[$];
    logic [31:0] last_rd = '0;

    always #5 clk = ~clk;

    sd_data_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_en = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic host_push(input logic [31:0] d, input bit kept);
        if (kept) exp_tx.push_back(d);
        bus_wr(A_DATA, d);
    endtask

    task automatic host_pop(input string tag);
        logic [31:0] v;
        bus_rd(A_DATA, v);
        if (exp_rx.size() == 0) check(tag, v, 32'hDEAD_BEEF);
        else check(tag, v, exp_rx.pop_front());
        last_rd = v;
    endtask

    task automatic rx_word(input logic [31:0] d);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        exp_rx.push_back(d);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Card-side monitor: compares every taken word with the scoreboard.
    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) check("R2 unexpected tx word", tx_data, 32'hFFFF_FFFF);
            else check("R2 tx order", tx_data, exp_tx.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        expect_reg("R1 debug", A_DBG, 32'h0001_0800);
        expect_reg("R1 status", A_STAT, 32'h0);
        expect_reg("R1 blocks", A_BLKS, 32'h0);
        expect_reg("R1 control", A_CTRL, 32'h0);

        // Write path: two blocks of two words
        bus_wr(A_BYTES, 32'd8);
        bus_wr(A_BLKS, 32'd2);
        for (int i = 0; i < 3; i++) host_push(32'hA000_0000 + i, 1'b1);
        expect_reg("R3 fill field", A_DBG, 32'h0001_0830);
        expect_reg("R8 idle no request", A_STAT, 32'h0);
        bus_wr(A_CTRL, 32'h1);
        expect_reg("R10 write start", A_DBG, 32'h0001_083A);
        expect_reg("R10 write data", A_DBG, 32'h0001_0833);
        expect_reg("R8 write request", A_STAT, 32'h1);
        tx_ready = 1'b1;
        repeat (6) @(negedge clk);
        expect_reg("R11 one block left", A_BLKS, 32'd1);
        expect_reg("R10 back to write start", A_DBG, 32'h0001_080A);
        host_push(32'hA000_0003, 1'b1);
        repeat (5) @(negedge clk);
        expect_reg("R11 done flag", A_STAT, 32'h200);
        expect_reg("R11 data mode", A_DBG, 32'h0001_0801);
        expect_reg("R11 zero blocks", A_BLKS, 32'd0);
        bus_wr(A_STAT, 32'h008);
        expect_reg("R6 zero bit keeps flag", A_STAT, 32'h200);
        bus_wr(A_STAT, 32'h200);
        expect_reg("R6 clear done", A_STAT, 32'h0);
        check("R2 all words out", exp_tx.size(), 0);

        // Overflow and write threshold
        tx_ready = 1'b0;
        bus_wr(A_BYTES, 32'd64);
        bus_wr(A_BLKS, 32'd1);
        bus_wr(A_CTRL, 32'h1);
        expect_reg("R10 empty start", A_DBG, 32'h0001_080A);
        bus_wr(A_DBG, 32'h0009_0800);
        expect_reg("R12 force from write start", A_DBG, 32'h0001_0801);
        bus_wr(A_CTRL, 32'h1);
        for (int i = 0; i < 12; i++) host_push(32'hB000_0000 + i, 1'b1);
        expect_reg("R8 request at 12", A_STAT, 32'h1);
        host_push(32'hB000_000C, 1'b1);
        expect_reg("R8 no request at 13", A_STAT, 32'h0);
        bus_wr(A_DBG, 32'h0009_0800);
        expect_reg("R12 force ignored in write data", A_DBG, 32'h0001_08D3);
        for (int i = 13; i < 16; i++) host_push(32'hB000_0000 + i, 1'b1);
        host_push(32'hBADD_0000, 1'b0);
        expect_reg("R4 error flag", A_STAT, 32'h008);
        expect_reg("R4 fill stays 16", A_DBG, 32'h0001_0903);
        tx_ready = 1'b1;
        repeat (25) @(negedge clk);
        expect_reg("R4 drained, no stray word", A_DBG, 32'h0001_0801);
        expect_reg("R11 done after 16", A_STAT, 32'h208);
        check("R4 dropped word absent", exp_tx.size(), 0);
        bus_wr(A_STAT, 32'h208);
        expect_reg("R6 clear both", A_STAT, 32'h0);
        tx_ready = 1'b0;

        // Read path: three blocks of eight words
        bus_wr(A_BYTES, 32'd32);
        bus_wr(A_BLKS, 32'd3);
        bus_wr(A_CTRL, 32'h3);
        expect_reg("R9 read data", A_DBG, 32'h0001_0802);
        expect_reg("R13 direction bit", A_CTRL, 32'h2);
        for (int i = 0; i < 3; i++) rx_word(32'hC000_0000 + i);
        expect_reg("R7 no request at 3", A_STAT, 32'h0);
        rx_word(32'hC000_0003);
        expect_reg("R7 request at 4", A_STAT, 32'h1);
        for (int i = 4; i < 16; i++) rx_word(32'hC000_0000 + i);
        repeat (2) @(negedge clk);
        check("R9 not ready when full", {31'b0, rx_ready}, 32'h0);
        expect_reg("R9 read wait", A_DBG, 32'h0001_0904);
        expect_reg("R11 read blocks left", A_BLKS, 32'd1);
        host_pop("R2 read order");
        repeat (2) @(negedge clk);
        expect_reg("R9 resume read data", A_DBG, 32'h0001_08F2);
        for (int i = 0; i < 8; i++) host_pop("R2 read order");
        for (int i = 16; i < 24; i++) rx_word(32'hC000_0000 + i);
        repeat (2) @(negedge clk);
        expect_reg("R11 read done state", A_DBG, 32'h0001_08F1);
        expect_reg("R11 read done flag", A_STAT, 32'h200);
        expect_reg("R11 read zero blocks", A_BLKS, 32'd0);
        for (int i = 0; i < 15; i++) host_pop("R2 read order");
        expect_reg("R5 empty read returns last", A_DATA, last_rd);
        expect_reg("R5 empty read error", A_STAT, 32'h208);
        expect_reg("R5 fill stays 0", A_DBG, 32'h0001_0801);
        bus_wr(A_STAT, 32'h208);

        // Start and direction rules
        bus_wr(A_CTRL, 32'h3);
        expect_reg("R13 go ignored with zero blocks", A_DBG, 32'h0001_0801);
        bus_wr(A_DATA, 32'h0000_0055);
        expect_reg("R13 write ignored in read direction", A_DBG, 32'h0001_0801);
        expect_reg("R13 no error from ignored write", A_STAT, 32'h0);

        // Recovery from read data
        bus_wr(A_BYTES, 32'd4);
        bus_wr(A_BLKS, 32'd1);
        bus_wr(A_CTRL, 32'h3);
        expect_reg("R12 read started", A_DBG, 32'h0001_0802);
        bus_wr(A_DBG, 32'h0009_0800);
        expect_reg("R12 force from read data", A_DBG, 32'h0001_0801);

        // Threshold programming
        bus_wr(A_DBG, 32'h0000_8E00);
        expect_reg("R3 thresholds read back", A_DBG, 32'h0000_8E01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule